// File: doc/BRIEF.md
# Multi-Window Pixel Signature Monitor

This block watches one display pixel stream and folds the pixels that fall inside each of up to four rectangular windows into a 32-bit multiple-input signature register (MISR). Each window has its own position and size. Windows may overlap, and each one keeps its own signature.

A start-of-frame strobe seeds every signature. An end-of-frame strobe latches each window's signature onto an output. On that same strobe the block updates two flags per window. The freeze flag reports that the image inside the window has not changed for a programmable number of frames. The error flag reports that the signature differs from a programmed reference value.

Software or a sequencer sets up the windows through a write-only register port.

Top module: `region_sig_monitor`

## Requirements
- R1: While reset is held, and after it is released, every latched signature reads 32'hFFFF_FFFF and every freeze and error flag reads 0 until the first end-of-frame strobe.
- R2: A pixel belongs to a window when `pix_valid` is 1, x0 <= `pix_x` < x0+width and y0 <= `pix_y` < y0+height. Pixels with `pix_valid` low, or outside the window, leave that window's signature unchanged.
- R3: Each window's MISR is set to all ones on `pix_sof`. On every pixel that belongs to the window, it moves to (S<<1) ^ (S[31] ? 32'h0040_0007 : 0) ^ zero-extended pixel data, which is the polynomial x^32+x^22+x^2+x+1. A pixel presented in the `pix_sof` cycle is folded onto the all-ones seed.
- R4: Overlapping windows accumulate independently. A pixel inside several windows updates each of them.
- R5: On a `pix_eof` cycle each window's running MISR is copied to its slice of `sig_out` (window n at bits 32n+31..32n). Signatures and flags change only in the cycle after a `pix_eof`.
- R6: At end of frame, the error flag of an enabled window is set exactly when its check-enable bit is 1 and the latched signature differs from the reference register. Otherwise it is cleared.
- R7: At end of frame, an enabled window whose new signature equals its previous latched signature increments a saturating repeat count; any other outcome resets the count to 0. The freeze flag is 1 exactly when the count is at least the threshold, and a threshold of 0 acts as 1. The first enabled frame after reset, or after a disabled frame, has no previous signature and counts as no repeat.
- R8: A window with width 0 or height 0 is disabled. At its end of frame both flags are cleared and its repeat history is discarded.
- R9: A configuration write with `cfg_we` high at address {window[1:0], field[2:0]} loads `cfg_wdata` into the chosen field. The fields are: 0 x0, 1 y0, 2 width, 3 height, 4 reference signature, 5 check enable (bit 0), 6 freeze threshold. Field 7 is ignored. All fields reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_valid | input | 1 | Pixel data and position are valid |
| pix_sof | input | 1 | Start-of-frame strobe, seeds all MISRs |
| pix_eof | input | 1 | End-of-frame strobe, latches signatures and flags |
| pix_x | input | COORD_W (12) | Horizontal pixel position |
| pix_y | input | COORD_W (12) | Vertical pixel position |
| pix_data | input | DATA_W (24) | Pixel value |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Window index and field code |
| cfg_wdata | input | 32 | Configuration write data |
| sig_out | output | NREG*32 (128) | Latched signature of each window |
| freeze_flag | output | NREG (4) | Frozen-image flag per window |
| error_flag | output | NREG (4) | Reference mismatch flag per window |

## Verification
The assertions assume that `pix_sof` and `pix_eof` never arrive in the same cycle, that no valid pixel comes with `pix_eof`, and that the reference registers are steady in the cycle of an end-of-frame strobe. The bench drives each frame as a lone start strobe, then rows of pixels with random idle cycles in which the position lines carry random values, then a lone end strobe. Configuration writes happen only between frames.

// File: rtl/sigmon_pkg.sv
package sigmon_pkg;
  localparam int SIG_W = 32;
  localparam logic [SIG_W-1:0] SIG_POLY = 32'h0040_0007;
  localparam logic [SIG_W-1:0] SIG_SEED = '1;

  typedef enum logic [2:0] {
    FLD_XSTART = 3'd0,
    FLD_YSTART = 3'd1,
    FLD_WIDTH  = 3'd2,
    FLD_HEIGHT = 3'd3,
    FLD_REF    = 3'd4,
    FLD_CHKEN  = 3'd5,
    FLD_THRESH = 3'd6
  } fld_e;

  function automatic logic [SIG_W-1:0] sig_step(input logic [SIG_W-1:0] cur,
                                                input logic [SIG_W-1:0] din);
    sig_step = {cur[SIG_W-2:0], 1'b0} ^ (cur[SIG_W-1] ? SIG_POLY : '0) ^ din;
  endfunction
endpackage

// File: rtl/sigmon_window.sv
module sigmon_window
  import sigmon_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  fld_e               wr_fld,
  input  logic [31:0]        wr_data,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  output logic               hit,
  output logic               off,
  output logic               chk_en,
  output logic [SIG_W-1:0]   ref_sig,
  output logic [CNT_W-1:0]   thresh
);
  localparam int EW = COORD_W + 1;

  logic [COORD_W-1:0] x0_q, y0_q, w_q, h_q;
  logic [EW-1:0]      x_end, y_end;
  logic               x_in, y_in;
  logic               unused_wr;

  assign unused_wr = ^{wr_data[31:COORD_W], wr_data[31:CNT_W]};

  // configuration fields, one clock enable per field
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q    <= '0;
      y0_q    <= '0;
      w_q     <= '0;
      h_q     <= '0;
      ref_sig <= '0;
      chk_en  <= 1'b0;
      thresh  <= '0;
    end else begin
      if (wr_en && wr_fld == FLD_XSTART) x0_q    <= wr_data[COORD_W-1:0];
      if (wr_en && wr_fld == FLD_YSTART) y0_q    <= wr_data[COORD_W-1:0];
      if (wr_en && wr_fld == FLD_WIDTH)  w_q     <= wr_data[COORD_W-1:0];
      if (wr_en && wr_fld == FLD_HEIGHT) h_q     <= wr_data[COORD_W-1:0];
      if (wr_en && wr_fld == FLD_REF)    ref_sig <= wr_data;
      if (wr_en && wr_fld == FLD_CHKEN)  chk_en  <= wr_data[0];
      if (wr_en && wr_fld == FLD_THRESH) thresh  <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    x_end = {1'b0, x0_q} + {1'b0, w_q};
    y_end = {1'b0, y0_q} + {1'b0, h_q};
    x_in  = ({1'b0, pix_x} >= {1'b0, x0_q}) && ({1'b0, pix_x} < x_end);
    y_in  = ({1'b0, pix_y} >= {1'b0, y0_q}) && ({1'b0, pix_y} < y_end);
    hit   = x_in && y_in;
    off   = (w_q == '0) || (h_q == '0);
  end
endmodule

// File: rtl/sigmon_sig.sv
module sigmon_sig
  import sigmon_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic              pix_eof,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              hit,
  input  logic              off,
  input  logic              chk_en,
  input  logic [SIG_W-1:0]  ref_sig,
  input  logic [CNT_W-1:0]  thresh,
  output logic [SIG_W-1:0]  sig_o,
  output logic              freeze_o,
  output logic              error_o
);
  logic [SIG_W-1:0] misr_q, misr_d, base;
  logic             misr_en;
  logic [CNT_W-1:0] rep_q, rep_d, rep_inc, thr_eff;
  logic             have_q, have_d, repeat_f, freeze_d, error_d;

  // next state
  always_comb begin
    base     = pix_sof ? SIG_SEED : misr_q;
    misr_en  = pix_sof || (pix_valid && hit);
    misr_d   = (pix_valid && hit) ? sig_step(base, SIG_W'(pix_data)) : base;
    repeat_f = have_q && (misr_q == sig_o);
    rep_inc  = (rep_q == '1) ? rep_q : rep_q + 1'b1;
    thr_eff  = (thresh == '0) ? CNT_W'(1) : thresh;
    rep_d    = (!off && repeat_f) ? rep_inc : '0;
    freeze_d = !off && repeat_f && (rep_inc >= thr_eff);
    error_d  = !off && chk_en && (misr_q != ref_sig);
    have_d   = !off;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misr_q   <= SIG_SEED;
      sig_o    <= SIG_SEED;
      rep_q    <= '0;
      have_q   <= 1'b0;
      freeze_o <= 1'b0;
      error_o  <= 1'b0;
    end else begin
      if (misr_en) misr_q <= misr_d;
      if (pix_eof) begin
        sig_o    <= misr_q;
        rep_q    <= rep_d;
        have_q   <= have_d;
        freeze_o <= freeze_d;
        error_o  <= error_d;
      end
    end
  end
endmodule

// File: rtl/region_sig_monitor.sv
module region_sig_monitor
  import sigmon_pkg::*;
#(
  parameter int NREG    = 4,
  parameter int COORD_W = 12,
  parameter int DATA_W  = 24,
  parameter int CNT_W   = 8,
  localparam int RIDX_W = $clog2(NREG),
  localparam int AW     = RIDX_W + 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_valid,
  input  logic                  pix_sof,
  input  logic                  pix_eof,
  input  logic [COORD_W-1:0]    pix_x,
  input  logic [COORD_W-1:0]    pix_y,
  input  logic [DATA_W-1:0]     pix_data,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [NREG*SIG_W-1:0] sig_out,
  output logic [NREG-1:0]       freeze_flag,
  output logic [NREG-1:0]       error_flag
);
  logic [1:0]            rst_pipe;
  logic                  rst_n_int;
  fld_e                  fld;
  logic [NREG-1:0]       reg_off, reg_chk;
  logic [NREG*SIG_W-1:0] reg_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];
  assign fld       = fld_e'(cfg_addr[2:0]);

  for (genvar r = 0; r < NREG; r++) begin : g_win
    logic             hit, wr_en;
    logic [CNT_W-1:0] thresh;

    assign wr_en = cfg_we && (cfg_addr[AW-1:3] == RIDX_W'(r));

    sigmon_window #(.COORD_W(COORD_W), .CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_fld(fld),
      .wr_data(cfg_wdata), .pix_x(pix_x), .pix_y(pix_y), .hit(hit),
      .off(reg_off[r]), .chk_en(reg_chk[r]),
      .ref_sig(reg_ref[r*SIG_W +: SIG_W]), .thresh(thresh)
    );

    sigmon_sig #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sig (
      .clk(clk), .rst_n(rst_n_int), .pix_valid(pix_valid), .pix_sof(pix_sof),
      .pix_eof(pix_eof), .pix_data(pix_data), .hit(hit), .off(reg_off[r]),
      .chk_en(reg_chk[r]), .ref_sig(reg_ref[r*SIG_W +: SIG_W]), .thresh(thresh),
      .sig_o(sig_out[r*SIG_W +: SIG_W]), .freeze_o(freeze_flag[r]),
      .error_o(error_flag[r])
    );
  end
endmodule

// File: rtl/sigmon_checker.sv
module sigmon_checker #(
  parameter int NREG = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_valid,
  input logic               pix_sof,
  input logic               pix_eof,
  input logic [NREG*32-1:0] sig_out,
  input logic [NREG-1:0]    freeze_flag,
  input logic [NREG-1:0]    error_flag,
  input logic [NREG-1:0]    reg_off,
  input logic [NREG-1:0]    reg_chk,
  input logic [NREG*32-1:0] reg_ref
);
  AST_SOF_EOF_APART: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> !pix_eof); // R5
  AST_NO_PIXEL_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eof |-> !pix_valid); // R5

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    AST_HOLD_OUTSIDE_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_eof |=> ($stable(sig_out[i*32 +: 32]) && $stable(freeze_flag[i])
                    && $stable(error_flag[i]))); // R5
    AST_OFF_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_eof && reg_off[i]) |=> (!freeze_flag[i] && !error_flag[i])); // R8
    AST_NO_ERR_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_eof && !reg_chk[i]) |=> !error_flag[i]); // R6
    AST_ERR_MEANS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error_flag[i]) |-> (sig_out[i*32 +: 32] != $past(reg_ref[i*32 +: 32]))); // R6
    AST_FREEZE_SAME_SIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(freeze_flag[i]) |-> $stable(sig_out[i*32 +: 32])); // R7
  end
endmodule

bind region_sig_monitor sigmon_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
  .pix_eof(pix_eof), .sig_out(sig_out), .freeze_flag(freeze_flag),
  .error_flag(error_flag), .reg_off(reg_off), .reg_chk(reg_chk), .reg_ref(reg_ref)
);

// File: tb/region_sig_monitor_test.sv
module region_sig_monitor_test;
  localparam int NREG = 4, COORD_W = 12, DATA_W = 24, CNT_W = 8, AW = 5;
  localparam int FW = 12, FH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_valid, pix_sof, pix_eof, cfg_we;
  logic [COORD_W-1:0] pix_x, pix_y;
  logic [DATA_W-1:0] pix_data;
  logic [AW-1:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [NREG*32-1:0] sig_out;
  logic [NREG-1:0] freeze_flag, error_flag;

  int checks = 0, errors = 0;
  int rx0[NREG], ry0[NREG], rw[NREG], rh[NREG], rthr[NREG];
  logic [31:0] rref[NREG], msig[NREG];
  logic rchk[NREG], mhave[NREG], mfz[NREG], merr[NREG];
  int mrep[NREG];

  always #2 clk = ~clk;

  region_sig_monitor uut (.*);

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] m_step(logic [31:0] s, logic [31:0] d);
    logic [31:0] n = s << 1;
    if (s[31]) n ^= 32'h0040_0007;
    return n ^ d;
  endfunction

  function automatic logic [DATA_W-1:0] pval(int x, int y, int seed);
    return DATA_W'((x * 37 + y * 101 + seed * 7919) ^ (seed << 9) ^ (x << 13));
  endfunction

  function automatic bit inside_w(int r, int x, int y);
    return x >= rx0[r] && x < rx0[r] + rw[r] && y >= ry0[r] && y < ry0[r] + rh[r];
  endfunction

  function automatic logic [31:0] region_sig(int r, int seed);
    logic [31:0] m = 32'hFFFF_FFFF;
    for (int y = 0; y < FH; y++)
      for (int x = 0; x < FW; x++)
        if (inside_w(r, x, y)) m = m_step(m, {8'h00, pval(x, y, seed)});
    return m;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // R9: address = {window, field}
  task automatic cfg_wr(int r, int fld, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'((r << 3) | fld); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_win(int r, int x0, int y0, int w, int h);
    rx0[r] = x0; ry0[r] = y0; rw[r] = w; rh[r] = h;
    cfg_wr(r, 0, x0); cfg_wr(r, 1, y0); cfg_wr(r, 2, w); cfg_wr(r, 3, h);
  endtask

  task automatic set_chk(int r, bit en, logic [31:0] refv, int thr);
    rchk[r] = en; rref[r] = refv; rthr[r] = thr;
    cfg_wr(r, 4, refv); cfg_wr(r, 5, {31'd0, en}); cfg_wr(r, 6, thr);
  endtask

  task automatic run_frame(int seed, string tag);
    logic [31:0] exp_sig[NREG];
    for (int r = 0; r < NREG; r++) exp_sig[r] = region_sig(r, seed);
    @(negedge clk); pix_sof = 1'b1;
    @(negedge clk); pix_sof = 1'b0;
    for (int y = 0; y < FH; y++)
      for (int x = 0; x < FW; x++) begin
        while ($urandom % 4 == 0) begin
          pix_valid = 1'b0; pix_x = COORD_W'($urandom % FW); pix_y = COORD_W'($urandom % FH);
          pix_data = DATA_W'($urandom);
          @(negedge clk);
        end
        pix_valid = 1'b1; pix_x = COORD_W'(x); pix_y = COORD_W'(y); pix_data = pval(x, y, seed);
        @(negedge clk);
        if (x == 0 && y == FH / 2)
          for (int r = 0; r < NREG; r++) chk("R5", "mid-frame hold", sig_out[r*32 +: 32], msig[r]);
      end
    pix_valid = 1'b0; pix_eof = 1'b1;
    @(negedge clk); pix_eof = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (rw[r] == 0 || rh[r] == 0) begin
        mfz[r] = 0; merr[r] = 0; mrep[r] = 0; mhave[r] = 0;
      end else begin
        bit match = mhave[r] && exp_sig[r] == msig[r];
        mrep[r] = match ? ((mrep[r] < 255) ? mrep[r] + 1 : 255) : 0;
        mfz[r]  = match && mrep[r] >= ((rthr[r] == 0) ? 1 : rthr[r]);
        merr[r] = rchk[r] && exp_sig[r] != rref[r];
        mhave[r] = 1;
      end
      msig[r] = exp_sig[r];
      chk(tag, $sformatf("signature w%0d", r), sig_out[r*32 +: 32], exp_sig[r]);
      chk((rw[r] == 0 || rh[r] == 0) ? "R8" : "R7", $sformatf("freeze w%0d", r), 32'(freeze_flag[r]), 32'(mfz[r]));
      chk((rw[r] == 0 || rh[r] == 0) ? "R8" : "R6", $sformatf("error w%0d", r), 32'(error_flag[r]), 32'(merr[r]));
    end
  endtask

  initial begin
    void'($urandom(1234));
    rst_n = 1'b0; pix_valid = 0; pix_sof = 0; pix_eof = 0; cfg_we = 0;
    pix_x = '0; pix_y = '0; pix_data = '0; cfg_addr = '0; cfg_wdata = '0;
    for (int r = 0; r < NREG; r++) begin
      rx0[r] = 0; ry0[r] = 0; rw[r] = 0; rh[r] = 0; rthr[r] = 0; rref[r] = 0; rchk[r] = 0;
      msig[r] = 32'hFFFF_FFFF; mhave[r] = 0; mfz[r] = 0; merr[r] = 0; mrep[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int r = 0; r < NREG; r++) begin
      chk("R1", "reset signature", sig_out[r*32 +: 32], 32'hFFFF_FFFF);
      chk("R1", "reset flags", {30'd0, freeze_flag[r], error_flag[r]}, 32'd0);
    end

    // R2 R4 R8: bounded, overlapping, zero-width and full-frame windows
    set_win(0, 2, 1, 4, 3); set_win(1, 4, 2, 5, 4); set_win(2, 0, 0, 0, 5); set_win(3, 0, 0, FW, FH);
    run_frame(11, "R2");
    run_frame(11, "R4");

    // R6: matching and mismatching references
    set_chk(0, 1, region_sig(0, 22), 1);
    set_chk(1, 1, 32'h0, 1);
    run_frame(22, "R6");

    // R7: threshold of 3 repeats
    set_chk(3, 0, 32'h0, 3);
    for (int k = 0; k < 5; k++) run_frame(33, "R7");

    // R8: disable then re-enable drops the repeat history
    set_win(1, 4, 2, 5, 0);
    run_frame(33, "R8");
    set_win(1, 4, 2, 5, 4);
    run_frame(33, "R8");

    // R9: single right-edge column via field writes
    set_win(2, FW - 1, 0, 1, FH);
    run_frame(44, "R9");

    // R3: random windows, seeds from a small pool so repeats occur
    for (int blk = 0; blk < 6; blk++) begin
      for (int r = 0; r < NREG; r++) begin
        int x0 = $urandom % FW, y0 = $urandom % FH;
        set_win(r, x0, y0, $urandom % (FW - x0 + 1), $urandom % (FH - y0 + 1));
        set_chk(r, 1'($urandom), ($urandom % 2) ? region_sig(r, 1 + $urandom % 3) : $urandom, $urandom % 4);
      end
      for (int f = 0; f < 5; f++) run_frame(1 + $urandom % 3, "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule